// File: doc/BRIEF.md
# Ternary Hybrid PWM Generator

This block converts 16-bit PCM audio samples into pulse-width-modulated drive for a full-bridge Class-D output stage. Each sample is split into two parts. The upper 13 bits set a coarse duration, which a down counter runs on the fast counter clock. The lower 3 bits pick one of eight sub-period taps, and the selected tap ends the pulse. The taps come from an external delay line that cuts one counter period into eight equal steps. Because of this split, the pulse width tracks the full 16-bit value while the counter clock only has to resolve 13 bits.

Two identical generator slices run side by side. Slice A takes the sample as it is, and slice B takes its bitwise complement. The load is connected between the two outputs, so it sees three levels: both outputs high, both low, or one high and one low. A rising edge on the reload strobe, which runs at the audio sample rate, starts a new period in both slices.

In this synchronous model, the tap bus is sampled on the counter clock. Every stage is counted in whole counter cycles.

Top module: `ternary_pwm_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no reload edge yet, pwm_a_o and pwm_b_o are both 0.
- R2: A reload edge is a clock edge where reload_i is 1 and was 0 at the previous edge. A strobe that is already high when reset is released is not an edge. A reload edge loads sample_i, and both outputs read 1 from the next cycle on.
- R3: Slice A loads sample_i[15:3] as its coarse count C. If the selected tap is always high, pwm_a_o stays high for exactly C+2 cycles, counted from the first cycle after the reload edge.
- R4: Slice A's fine index is sample_i[2:0]. Bit k of tap_i is tap k. Once the coarse count has reached zero, the output clears at the first edge where tap_i[fine index] is 1. Any other tap has no effect.
- R5: A sample whose coarse and fine parts are both zero gives a pulse of 2 cycles on pwm_a_o, after which the output falls and stays low.
- R6: Slice B applies R3 and R4 to ~sample_i. Its coarse count is ~sample_i[15:3] and its fine index is ~sample_i[2:0].
- R7: A reload edge that arrives while a pulse is still high restarts both slices with the new sample. The new pulse is measured from that edge.
- R8: sample_i is captured only on a reload edge. A change while a count is running has no effect, and a reload held high starts no further pulse.
- R9: An output rises only after a reload edge and falls only on a selected tap. Once low, it stays low until the next reload edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 1 | Sample-rate reload strobe; a rising edge starts a period |
| sample_i | input | 16 | PCM sample: coarse part in [15:3], fine part in [2:0] |
| tap_i | input | 8 | Fine tap strobes from the delay line; bit k is tap k |
| pwm_a_o | output | 1 | Bridge drive from the true sample |
| pwm_b_o | output | 1 | Bridge drive from the complemented sample |

## Verification
The bench targets the zero sample. A design that waits for the counter to wrap, or that skips the fine stage, would give a stuck-high output or a pulse of the wrong length instead of two cycles. It also gates the tap bus so that only one tap is high, which catches a mux indexed by the wrong bits or by slice B's index: such a design would fall on an unselected tap or never fall. Reloads in mid-pulse, sample changes in mid-count and a reload held high are aimed at designs that relaunch on a level, that sample continuously, or that let a new reload extend the old pulse rather than restart it. Complement samples with very different coarse parts show whether slice B really inverts both fields.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned FINE_W   = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FINE  = 2'd2
  } pwm_state_e;
endpackage

// File: rtl/pwm_edge_det.sv
module pwm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  // reset to 1: a strobe already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/pwm_tap_mux.sv
module pwm_tap_mux #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_TAPS = 1 << SEL_W
) (
  input  logic [N_TAPS-1:0] taps_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < N_TAPS; k++) begin
      if (sel_i == SEL_W'(k)) hit_o = taps_i[k];
    end
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_pkg::*;
#(
  parameter int unsigned SMP_W = SAMPLE_W,
  parameter int unsigned FIN_W = FINE_W,
  localparam int unsigned CRS_W  = SMP_W - FIN_W,
  localparam int unsigned N_TAPS = 1 << FIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [N_TAPS-1:0] tap_i,
  output logic              pwm_o
);
  pwm_state_e       state_q;
  logic [CRS_W-1:0] cnt_q;
  logic [FIN_W-1:0] sel_q;
  logic             tap_hit;

  pwm_tap_mux #(.SEL_W(FIN_W)) i_tap_mux (
    .taps_i (tap_i),
    .sel_i  (sel_q),
    .hit_o  (tap_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
      pwm_o   <= 1'b0;
    end else if (load_i) begin
      state_q <= ST_COUNT;
      cnt_q   <= sample_i[SMP_W-1:FIN_W];
      sel_q   <= sample_i[FIN_W-1:0];
      pwm_o   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_COUNT: begin
          if (cnt_q == '0) state_q <= ST_FINE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FINE: begin
          if (tap_hit) begin
            pwm_o   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ternary_pwm_gen.sv
module ternary_pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned SMP_W = SAMPLE_W,
  parameter int unsigned FIN_W = FINE_W,
  localparam int unsigned N_TAPS = 1 << FIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [N_TAPS-1:0] tap_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  logic       load;
  logic [1:0] pwm;

  pwm_edge_det i_edge_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (reload_i),
    .rise_o   (load)
  );

  for (genvar g = 0; g < 2; g++) begin : gen_slice
    logic [SMP_W-1:0] slice_sample;
    if (g == 0) begin : gen_true
      assign slice_sample = sample_i;
    end else begin : gen_inv
      assign slice_sample = ~sample_i;
    end

    pwm_slice #(.SMP_W(SMP_W), .FIN_W(FIN_W)) i_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .sample_i (slice_sample),
      .tap_i    (tap_i),
      .pwm_o    (pwm[g])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
endmodule

// File: rtl/ternary_pwm_gen_chk.sv
module ternary_pwm_gen_chk #(
  parameter int unsigned N_TAPS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reload_i,
  input logic [N_TAPS-1:0] tap_i,
  input logic              pwm_a_o,
  input logic              pwm_b_o
);
  logic rl_q;
  logic edge_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rl_q <= 1'b1;
    else         rl_q <= reload_i;
  end
  assign edge_seen = reload_i && !rl_q;

  assert_load_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> (pwm_a_o && pwm_b_o));

  assert_a_fall_on_tap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_a_o && !edge_seen && !(|tap_i)) |=> pwm_a_o);

  assert_b_fall_on_tap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_b_o && !edge_seen && !(|tap_i)) |=> pwm_b_o);

  assert_a_stays_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_a_o && !edge_seen) |=> !pwm_a_o);

  assert_b_stays_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_b_o && !edge_seen) |=> !pwm_b_o);
endmodule

bind ternary_pwm_gen ternary_pwm_gen_chk #(.N_TAPS(N_TAPS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .reload_i (reload_i),
  .tap_i    (tap_i),
  .pwm_a_o  (pwm_a_o),
  .pwm_b_o  (pwm_b_o)
);

// File: tb/test_ternary_pwm_gen.sv
`timescale 1ns/1ps
module test_ternary_pwm_gen;
  localparam int LIMIT = 9000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reload_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [7:0]  tap_i = 8'hFF;
  logic        pwm_a_o, pwm_b_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  ternary_pwm_gen i_ternary_pwm_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload_i),
    .sample_i (sample_i),
    .tap_i    (tap_i),
    .pwm_a_o  (pwm_a_o),
    .pwm_b_o  (pwm_b_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < LIMIT; i++) begin
      if (!pwm_a_o && !pwm_b_o) break;
      @(negedge clk_i);
    end
  endtask

  // count high cycles of both outputs after a reload edge
  task automatic run_pulse(input logic [15:0] s, output int wa, output int wb);
    wa = 0; wb = 0;
    @(negedge clk_i);
    sample_i = s; reload_i = 1'b1;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk_i);
      if (i == 0) reload_i = 1'b0;
      if (pwm_a_o) wa++;
      if (pwm_b_o) wb++;
      if (!pwm_a_o && !pwm_b_o) break;
    end
  endtask

  function automatic int exp_w(input logic [15:0] s);
    return int'(s >> 3) + 2;
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    check(!pwm_a_o && !pwm_b_o, "R1 in reset", {pwm_a_o, pwm_b_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!pwm_a_o && !pwm_b_o, "R1 after release", {pwm_a_o, pwm_b_o}, 0);
  endtask

  task automatic t_load_sets();
    @(negedge clk_i);
    sample_i = 16'h0100; reload_i = 1'b1;
    @(negedge clk_i);
    reload_i = 1'b0;
    check(pwm_a_o && pwm_b_o, "R2 both high after edge", {pwm_a_o, pwm_b_o}, 3);
    wait_idle();
  endtask

  task automatic t_coarse();
    int wa, wb;
    run_pulse(16'h0050, wa, wb);
    check(wa == exp_w(16'h0050), "R3 coarse 10", wa, exp_w(16'h0050));
    run_pulse(16'h1234, wa, wb);
    check(wa == exp_w(16'h1234), "R3 coarse 0x246", wa, exp_w(16'h1234));
    check(wb == exp_w(~16'h1234), "R6 complement of 0x1234", wb, exp_w(~16'h1234));
    run_pulse(16'hFFF0, wa, wb);
    check(wb == exp_w(16'h000F), "R6 complement small", wb, exp_w(16'h000F));
  endtask

  task automatic t_zero();
    int wa, wb;
    run_pulse(16'h0000, wa, wb);
    check(wa == 2, "R5 zero sample width", wa, 2);
    repeat (5) @(negedge clk_i);
    check(!pwm_a_o, "R5 zero sample stays low", pwm_a_o, 0);
  endtask

  task automatic t_fine();
    // only tap 5 high: A with fine 5 ends at C+2
    int w = 0;
    tap_i = 8'b0010_0000;
    @(negedge clk_i);
    sample_i = (16'd4 << 3) | 16'd5; reload_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (i == 0) reload_i = 1'b0;
      if (pwm_a_o) w++;
    end
    check(w == 6, "R4 selected tap 5 ends pulse", w, 6);
    // fine 3 with tap 5 only: must hold high
    @(negedge clk_i);
    sample_i = (16'd4 << 3) | 16'd3; reload_i = 1'b1;
    repeat (20) @(negedge clk_i);
    reload_i = 1'b0;
    check(pwm_a_o, "R4 unselected tap ignored", pwm_a_o, 1);
    tap_i = 8'b0000_1000;
    @(negedge clk_i);
    check(!pwm_a_o, "R4 tap 3 ends pulse", pwm_a_o, 0);
    tap_i = 8'hFF;
    wait_idle();
  endtask

  task automatic t_restart();
    int w = 0;
    @(negedge clk_i);
    sample_i = 16'd20 << 3; reload_i = 1'b1;
    @(negedge clk_i);
    reload_i = 1'b0;
    repeat (4) @(negedge clk_i);
    sample_i = 16'd3 << 3; reload_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (i == 0) reload_i = 1'b0;
      if (pwm_a_o) w++;
    end
    check(w == 5, "R7 restart with coarse 3", w, 5);
    wait_idle();
  endtask

  task automatic t_capture();
    int w = 0;
    @(negedge clk_i);
    sample_i = 16'd10 << 3; reload_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (i == 0) reload_i = 1'b0;
      if (i == 2) sample_i = 16'h0000;
      if (pwm_a_o) w++;
    end
    check(w == 12, "R8 mid-count sample change ignored", w, 12);
    wait_idle();
    // reload held high: one pulse only
    w = 0;
    @(negedge clk_i);
    sample_i = 16'd2 << 3; reload_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (pwm_a_o) w++;
    end
    check(w == 4, "R8 held reload single pulse", w, 4);
    check(!pwm_a_o, "R9 stays low without edge", pwm_a_o, 0);
    reload_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_load_sets();
    t_coarse();
    t_zero();
    t_fine();
    t_restart();
    t_capture();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule